// File: doc/BRIEF.md
# Five-wide VLIW Bundle Packer

The packer receives scalar operations one at a time, in program order, over a valid/ready handshake. Each operation carries a class code, a destination register and up to three source registers, each with its own enable bit. The packer groups these operations into issue bundles and sends one bundle per accepted output transfer. A bundle has five ALU lanes and one branch lane. Lanes 0 to 3 are general lanes. Lane 4 is the only lane that can also run transcendental operations.

Packing is greedy and never reorders operations. Each operation joins the bundle being built if that bundle has a lane the operation may use, and if the operation does not read a register that an ALU operation already in the bundle writes. Otherwise the bundle is closed, and the operation becomes the first member of the next bundle. A dot product takes all four general lanes at once. A flush input pushes out a partially filled bundle.

Top module: `vliw5_packer`

## Requirements
- R1: Class codes are ADD=0, MUL=1, MAD=2, IADD=3, TRANS=4, DOT=5, BRANCH=6 and NOP=7. In an output bundle, lane i uses `out_cls[3i+:3]`, `out_dst[W*i+:W]`, `out_src_en[3i+:3]` and `out_src[3W*i+:3W]`, with source k at offset `W*k` inside its lane. Branch source k is at `out_br_src[W*k+:W]`. Every lane whose mask bit is clear shows class 7 with all other fields zero. When no branch is present, the branch fields are zero.
- R2: A general operation (classes 0 to 3) takes the lowest free lane among 0 to 3. If lanes 0 to 3 are all taken, it uses lane 4. If lane 4 is also taken, the bundle closes and the operation opens the next bundle.
- R3: A transcendental operation goes only into lane 4. If lane 4 is already taken, the bundle closes and the operation starts the next bundle in lane 4.
- R4: A dot product is copied into lanes 0 to 3 and sets all four mask bits. It needs all four general lanes to be free, and otherwise closes the bundle. Lane 4 stays usable for a later operation.
- R5: A bundle holds at most one branch. A second branch closes the bundle.
- R6: An operation with an enabled source equal to the destination of an ALU operation already in the bundle closes the bundle. A branch's destination field never counts as a write.
- R7: Operations leave in program order. A bundle closes only when the next operation cannot join it, or on flush.
- R8: While `flush` is high, `in_ready` is low. A non-empty bundle is emitted once the output stage can take it. Flushing an empty bundle emits nothing.
- R9: While `out_valid` is high and `out_ready` is low, all outputs hold steady. When a bundle must close and the output stage is full, `in_ready` is low.
- R10: An input of class 7 is accepted and dropped. It neither joins nor closes a bundle.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Close and emit the partial bundle |
| in_valid | input | 1 | Input operation present |
| in_ready | output | 1 | Operation accepted this cycle |
| in_cls | input | 3 | Operation class code |
| in_dst | input | REG_W | Destination register |
| in_src_en | input | 3 | Enable bit for each source |
| in_src | input | 3*REG_W | Three source registers |
| out_valid | output | 1 | Bundle present |
| out_ready | input | 1 | Downstream takes the bundle |
| out_alu_mask | output | 5 | Occupied ALU lanes |
| out_br_valid | output | 1 | Branch lane occupied |
| out_cls | output | 15 | Class code for each lane |
| out_dst | output | 5*REG_W | Destination register for each lane |
| out_src_en | output | 15 | Source enables for each lane |
| out_src | output | 15*REG_W | Source registers for each lane |
| out_br_src_en | output | 3 | Branch source enables |
| out_br_src | output | 3*REG_W | Branch source registers |

## Verification
The bench sweeps every ordered pair of class codes, both with and without a read of the first operation's destination. It then runs directed cases for six general operations, two transcendentals, a dot product after a general operation, two branches, and a dropped no-op placed between dependent operations. These cases catch the typical faults: a transcendental in a general lane, a dot product that overwrites an occupied lane, a second branch overwriting the first, or a dependent operation let into the bundle whose result it reads. A backpressure case stalls the output while a bundle must close, which exposes a design that drops or overwrites a held bundle. A long pseudo-random stream with random `out_ready` and only four registers in use checks ordering and hazard closing under heavy dependence.

// File: rtl/vp_pkg.sv
`timescale 1ns/1ps
package vp_pkg;
  localparam int ALU_SLOTS = 5;
  localparam int GEN_SLOTS = 4;
  localparam int SRC_N     = 3;
  localparam int CLS_W     = 3;

  typedef enum logic [CLS_W-1:0] {
    OPC_ADD   = 3'd0,
    OPC_MUL   = 3'd1,
    OPC_MAD   = 3'd2,
    OPC_IADD  = 3'd3,
    OPC_TRANS = 3'd4,
    OPC_DOT   = 3'd5,
    OPC_BR    = 3'd6,
    OPC_NOP   = 3'd7
  } opc_e;

  // one-hot of the lowest clear bit; zero when all bits are set
  function automatic logic [GEN_SLOTS-1:0] lowest_free(input logic [GEN_SLOTS-1:0] occ);
    logic [GEN_SLOTS-1:0] res;
    res = '0;
    for (int i = GEN_SLOTS-1; i >= 0; i--) begin
      if (!occ[i]) begin
        res = '0;
        res[i] = 1'b1;
      end
    end
    return res;
  endfunction

  function automatic logic is_general(input logic [CLS_W-1:0] c);
    return (c == OPC_ADD) || (c == OPC_MUL) || (c == OPC_MAD) || (c == OPC_IADD);
  endfunction
endpackage

// File: rtl/vp_slot_alloc.sv
`timescale 1ns/1ps
module vp_slot_alloc
  import vp_pkg::*;
(
  input  logic [ALU_SLOTS-1:0] occ,
  input  logic                 br_occ,
  input  logic [CLS_W-1:0]     cls,
  output logic                 fit,
  output logic [ALU_SLOTS-1:0] place,
  output logic                 place_br
);
  localparam int HI = ALU_SLOTS - 1;

  logic [GEN_SLOTS-1:0] gen_occ;
  logic [GEN_SLOTS-1:0] gen_pick;
  logic                 gen_full;
  logic                 hi_free;

  assign gen_occ  = occ[GEN_SLOTS-1:0];
  assign gen_pick = lowest_free(gen_occ);
  assign gen_full = &gen_occ;
  assign hi_free  = !occ[HI];

  always_comb begin
    fit      = 1'b0;
    place    = '0;
    place_br = 1'b0;
    if (is_general(cls)) begin
      if (!gen_full) begin
        fit = 1'b1;
        place[GEN_SLOTS-1:0] = gen_pick;
      end else if (hi_free) begin
        fit = 1'b1;
        place[HI] = 1'b1;
      end
    end else if (cls == OPC_TRANS) begin
      if (hi_free) begin
        fit = 1'b1;
        place[HI] = 1'b1;
      end
    end else if (cls == OPC_DOT) begin
      if (gen_occ == '0) begin
        fit = 1'b1;
        place[GEN_SLOTS-1:0] = '1;
      end
    end else if (cls == OPC_BR) begin
      if (!br_occ) begin
        fit = 1'b1;
        place_br = 1'b1;
      end
    end else begin
      fit = 1'b1;  // no-op: consumes nothing
    end
  end
endmodule

// File: rtl/vp_hazard.sv
`timescale 1ns/1ps
module vp_hazard
  import vp_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [(1<<REG_W)-1:0]   written,
  input  logic [SRC_N-1:0]        src_en,
  input  logic [SRC_N*REG_W-1:0]  src,
  output logic                    hazard
);
  logic [SRC_N-1:0] hit;

  for (genvar k = 0; k < SRC_N; k++) begin : g_src
    assign hit[k] = src_en[k] & written[src[k*REG_W +: REG_W]];
  end

  assign hazard = |hit;
endmodule

// File: rtl/vp_out_reg.sv
`timescale 1ns/1ps
module vp_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] dout,
  output logic         free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a stalled bundle stays put
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dout));
  // R9: a new bundle is loaded only when the stage can give up its content
  a_r9_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free);
endmodule

// File: rtl/vliw5_packer.sv
`timescale 1ns/1ps
module vliw5_packer
  import vp_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [CLS_W-1:0]               in_cls,
  input  logic [REG_W-1:0]               in_dst,
  input  logic [SRC_N-1:0]               in_src_en,
  input  logic [SRC_N*REG_W-1:0]         in_src,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [ALU_SLOTS-1:0]           out_alu_mask,
  output logic                           out_br_valid,
  output logic [ALU_SLOTS*CLS_W-1:0]     out_cls,
  output logic [ALU_SLOTS*REG_W-1:0]     out_dst,
  output logic [ALU_SLOTS*SRC_N-1:0]     out_src_en,
  output logic [ALU_SLOTS*SRC_N*REG_W-1:0] out_src,
  output logic [SRC_N-1:0]               out_br_src_en,
  output logic [SRC_N*REG_W-1:0]         out_br_src
);
  localparam int NREG  = 1 << REG_W;
  localparam int SRC_W = SRC_N * REG_W;
  localparam int BW    = ALU_SLOTS + 1 + ALU_SLOTS*CLS_W + ALU_SLOTS*REG_W
                       + ALU_SLOTS*SRC_N + ALU_SLOTS*SRC_W + SRC_N + SRC_W;

  // bundle under construction
  logic [ALU_SLOTS-1:0] acc_mask;
  logic                 acc_br;
  logic [CLS_W-1:0]     acc_cls [ALU_SLOTS];
  logic [REG_W-1:0]     acc_dst [ALU_SLOTS];
  logic [SRC_N-1:0]     acc_sen [ALU_SLOTS];
  logic [SRC_W-1:0]     acc_src [ALU_SLOTS];
  logic [SRC_N-1:0]     acc_bsen;
  logic [SRC_W-1:0]     acc_bsrc;
  logic [NREG-1:0]      written;

  // named internal events
  logic                 cur_fit, new_fit, haz, dep_block;
  logic [ALU_SLOTS-1:0] cur_place, new_place, sel_place;
  logic                 cur_br, new_br, sel_br;
  logic                 take, fit, acc_busy, out_free;
  logic                 close_op, close_fl, close, accept;

  vp_slot_alloc u_alloc_cur (
    .occ(acc_mask), .br_occ(acc_br), .cls(in_cls),
    .fit(cur_fit), .place(cur_place), .place_br(cur_br)
  );

  vp_slot_alloc u_alloc_new (
    .occ('0), .br_occ(1'b0), .cls(in_cls),
    .fit(new_fit), .place(new_place), .place_br(new_br)
  );

  vp_hazard #(.REG_W(REG_W)) u_hazard (
    .written(written), .src_en(in_src_en), .src(in_src), .hazard(haz)
  );

  assign dep_block = haz && (in_cls != OPC_NOP);
  assign take      = in_valid && !flush;
  assign fit       = cur_fit && !dep_block;
  assign acc_busy  = (|acc_mask) || acc_br;
  assign close_op  = take && !fit;
  assign close_fl  = flush && acc_busy;
  assign close     = (close_op || close_fl) && out_free;
  assign in_ready  = !flush && (fit || (out_free && new_fit));
  assign accept    = in_valid && in_ready;
  assign sel_place = !accept ? '0   : (fit ? cur_place : new_place);
  assign sel_br    = !accept ? 1'b0 : (fit ? cur_br    : new_br);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_mask <= '0;
      acc_br   <= 1'b0;
      acc_bsen <= '0;
      acc_bsrc <= '0;
      written  <= '0;
      for (int i = 0; i < ALU_SLOTS; i++) begin
        acc_cls[i] <= OPC_NOP;
        acc_dst[i] <= '0;
        acc_sen[i] <= '0;
        acc_src[i] <= '0;
      end
    end else begin
      if (close) begin
        acc_mask <= '0;
        acc_br   <= 1'b0;
        acc_bsen <= '0;
        acc_bsrc <= '0;
        written  <= '0;
        for (int i = 0; i < ALU_SLOTS; i++) begin
          acc_cls[i] <= OPC_NOP;
          acc_dst[i] <= '0;
          acc_sen[i] <= '0;
          acc_src[i] <= '0;
        end
      end
      if (accept) begin
        acc_mask <= (close ? '0 : acc_mask) | sel_place;
        for (int i = 0; i < ALU_SLOTS; i++) begin
          if (sel_place[i]) begin
            acc_cls[i] <= in_cls;
            acc_dst[i] <= in_dst;
            acc_sen[i] <= in_src_en;
            acc_src[i] <= in_src;
          end
        end
        if (sel_br) begin
          acc_br   <= 1'b1;
          acc_bsen <= in_src_en;
          acc_bsrc <= in_src;
        end
        if (|sel_place) written[in_dst] <= 1'b1;
      end
    end
  end

  // flatten the bundle for the output stage
  logic [ALU_SLOTS*CLS_W-1:0] f_cls;
  logic [ALU_SLOTS*REG_W-1:0] f_dst;
  logic [ALU_SLOTS*SRC_N-1:0] f_sen;
  logic [ALU_SLOTS*SRC_W-1:0] f_src;

  for (genvar i = 0; i < ALU_SLOTS; i++) begin : g_flat
    assign f_cls[i*CLS_W +: CLS_W] = acc_cls[i];
    assign f_dst[i*REG_W +: REG_W] = acc_dst[i];
    assign f_sen[i*SRC_N +: SRC_N] = acc_sen[i];
    assign f_src[i*SRC_W +: SRC_W] = acc_src[i];
  end

  logic [BW-1:0] bundle_d, bundle_q;
  assign bundle_d = {acc_mask, acc_br, f_cls, f_dst, f_sen, f_src, acc_bsen, acc_bsrc};

  vp_out_reg #(.W(BW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(close), .din(bundle_d),
    .out_ready(out_ready), .out_valid(out_valid), .dout(bundle_q), .free(out_free)
  );

  assign {out_alu_mask, out_br_valid, out_cls, out_dst, out_src_en, out_src,
          out_br_src_en, out_br_src} = bundle_q;

  // R2: the allocator never picks a lane that is already occupied
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    accept && fit |-> (cur_place & acc_mask) == '0);
  // R6: a read of a register written in the bundle forces a close when possible
  a_r6_dep_closes: assert property (@(posedge clk) disable iff (!rst_n)
    take && dep_block && acc_busy && out_free |-> close);
  // R8: no input is taken while flushing
  a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);
  // R8: a flush with a free output empties the bundle
  a_r8_flush_drains: assert property (@(posedge clk) disable iff (!rst_n)
    flush && out_free |=> !acc_busy);

  for (genvar i = 0; i < ALU_SLOTS; i++) begin : g_out_chk
    // R1: unoccupied lanes present a no-op
    a_r1_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_alu_mask[i] |->
        out_cls[i*CLS_W +: CLS_W] == OPC_NOP && out_dst[i*REG_W +: REG_W] == '0);
    // R4: a dot product always occupies the four general lanes
    a_r4_dot_full: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_alu_mask[i] && out_cls[i*CLS_W +: CLS_W] == OPC_DOT |->
        out_alu_mask[GEN_SLOTS-1:0] == '1);
    if (i < GEN_SLOTS) begin : g_gen
      // R3: transcendentals never appear in a general lane
      a_r3_no_trans_gen: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_alu_mask[i] |-> out_cls[i*CLS_W +: CLS_W] != OPC_TRANS);
    end
  end
endmodule

// File: tb/vliw5_packer_tb_top.sv
`timescale 1ns/1ps
module vliw5_packer_tb_top;
  localparam int RW = 5;
  localparam int NR = 1 << RW;
  localparam int BW = 5 + 1 + 15 + 5*RW + 15 + 15*RW + 3 + 3*RW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [2:0] in_cls = 3'd7;
  logic [RW-1:0] in_dst = '0;
  logic [2:0] in_src_en = '0;
  logic [3*RW-1:0] in_src = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [4:0] out_alu_mask;
  logic out_br_valid;
  logic [14:0] out_cls;
  logic [5*RW-1:0] out_dst;
  logic [14:0] out_src_en;
  logic [15*RW-1:0] out_src;
  logic [2:0] out_br_src_en;
  logic [3*RW-1:0] out_br_src;

  always #4 clk = ~clk;  // 125 MHz

  vliw5_packer #(.REG_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_dst(in_dst), .in_src_en(in_src_en), .in_src(in_src),
    .out_valid(out_valid), .out_ready(out_ready), .out_alu_mask(out_alu_mask),
    .out_br_valid(out_br_valid), .out_cls(out_cls), .out_dst(out_dst),
    .out_src_en(out_src_en), .out_src(out_src), .out_br_src_en(out_br_src_en),
    .out_br_src(out_br_src)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int bp_mode = 0;
  logic [31:0] rnd = 32'h1234_5678;
  string cur_tag = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // ---------------- reference model: prefix count of general lanes ----------------
  int m_gcnt;
  bit m_s4, m_br;
  bit [NR-1:0] m_wr;
  logic [4:0] m_mask;
  logic [2:0] m_cls [5];
  logic [RW-1:0] m_dst [5];
  logic [2:0] m_sen [5];
  logic [3*RW-1:0] m_src [5];
  logic [2:0] m_bsen;
  logic [3*RW-1:0] m_bsrc;
  logic [BW-1:0] exp_q [$];
  string tag_q [$];

  function automatic void m_clear();
    m_gcnt = 0; m_s4 = 0; m_br = 0; m_wr = '0; m_mask = '0;
    m_bsen = '0; m_bsrc = '0;
    for (int i = 0; i < 5; i++) begin
      m_cls[i] = 3'd7; m_dst[i] = '0; m_sen[i] = '0; m_src[i] = '0;
    end
  endfunction

  function automatic logic [BW-1:0] m_vec();
    logic [14:0] c; logic [5*RW-1:0] d; logic [14:0] se; logic [15*RW-1:0] s;
    for (int i = 0; i < 5; i++) begin
      c[3*i +: 3] = m_cls[i];
      d[RW*i +: RW] = m_dst[i];
      se[3*i +: 3] = m_sen[i];
      s[3*RW*i +: 3*RW] = m_src[i];
    end
    return {m_mask, m_br, c, d, se, s, m_bsen, m_bsrc};
  endfunction

  function automatic void m_emit();
    if (m_mask != 0 || m_br) begin
      exp_q.push_back(m_vec());
      tag_q.push_back(cur_tag);
    end
    m_clear();
  endfunction

  function automatic void m_put(input int sl, input logic [2:0] c, input logic [RW-1:0] d,
                                input logic [2:0] se, input logic [3*RW-1:0] s);
    m_cls[sl] = c; m_dst[sl] = d; m_sen[sl] = se; m_src[sl] = s;
    m_mask[sl] = 1'b1;
    m_wr[d] = 1'b1;
  endfunction

  function automatic bit m_can(input logic [2:0] c, input logic [2:0] se, input logic [3*RW-1:0] s);
    for (int k = 0; k < 3; k++)
      if (se[k] && m_wr[s[RW*k +: RW]]) return 0;
    if (c <= 3) return (m_gcnt < 4) || !m_s4;
    if (c == 4) return !m_s4;
    if (c == 5) return m_gcnt == 0;
    return !m_br;
  endfunction

  function automatic void model_push(input logic [2:0] c, input logic [RW-1:0] d,
                                     input logic [2:0] se, input logic [3*RW-1:0] s);
    if (c == 3'd7) return;
    if (!m_can(c, se, s)) m_emit();
    if (c <= 3) begin
      if (m_gcnt < 4) begin m_put(m_gcnt, c, d, se, s); m_gcnt++; end
      else begin m_put(4, c, d, se, s); m_s4 = 1; end
    end else if (c == 4) begin
      m_put(4, c, d, se, s); m_s4 = 1;
    end else if (c == 5) begin
      for (int j = 0; j < 4; j++) m_put(j, c, d, se, s);
      m_gcnt = 4;
    end else begin
      m_br = 1; m_bsen = se; m_bsrc = s;
    end
  endfunction

  // ---------------- drivers ----------------
  task automatic push(input logic [2:0] c, input logic [RW-1:0] d,
                      input logic [2:0] se, input logic [3*RW-1:0] s);
    model_push(c, d, se, s);
    @(negedge clk);
    in_valid = 1; in_cls = c; in_dst = d; in_src_en = se; in_src = s;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 in_valid = 0;
  endtask

  task automatic do_flush();
    m_emit();
    @(negedge clk);
    flush = 1;
    #1;
    while (!(!out_valid || out_ready)) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 flush = 0;
  endtask

  function automatic logic [3*RW-1:0] srcs(input int a, input int b, input int e);
    return {RW'(e), RW'(b), RW'(a)};
  endfunction

  // ---------------- output backpressure ----------------
  logic [31:0] bp_rnd = 32'hCAFE_0001;
  initial begin
    forever begin
      @(negedge clk);
      bp_rnd = step(bp_rnd);
      case (bp_mode)
        0: out_ready = 1'b1;
        1: out_ready = bp_rnd[0] | bp_rnd[3];
        default: out_ready = 1'b0;
      endcase
    end
  end

  // ---------------- monitor ----------------
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid && out_ready) begin
        logic [BW-1:0] got;
        got = {out_alu_mask, out_br_valid, out_cls, out_dst, out_src_en, out_src,
               out_br_src_en, out_br_src};
        if (exp_q.size() == 0) begin
          check(0, "R7", "unexpected bundle", got, '0);
        end else begin
          logic [BW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(got == e, t, "bundle contents", got, e);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    m_clear();
    repeat (5) @(negedge clk);
    rst_n = 1;
    #1;
    check(out_valid == 0, "R11", "out_valid after reset", BW'(out_valid), '0);
    check(in_ready == 1, "R11", "in_ready after reset", BW'(in_ready), BW'(1));

    // R1 sweep: all class pairs, with and without a read of the first result
    cur_tag = "R1";
    for (int c1 = 0; c1 < 8; c1++) begin
      for (int c2 = 0; c2 < 8; c2++) begin
        for (int dep = 0; dep < 2; dep++) begin
          push(3'(c1), RW'(1), 3'b011, srcs(4, 5, 0));
          push(3'(c2), RW'(2), 3'b001, srcs(dep ? 1 : 6, 0, 0));
          do_flush();
        end
      end
    end

    // R2: six general operations, the sixth opens a new bundle
    cur_tag = "R2";
    for (int i = 0; i < 6; i++) push(3'(i % 4), RW'(10 + i), 3'b111, srcs(20, 21, 22));
    do_flush();

    // R3: two transcendentals cannot share lane 4
    cur_tag = "R3";
    push(3'd0, RW'(1), 3'b000, '0);
    push(3'd4, RW'(2), 3'b001, srcs(7, 0, 0));
    push(3'd4, RW'(3), 3'b001, srcs(8, 0, 0));
    do_flush();

    // R4: dot then lane 4, then a general op closes; a dot after a general op closes
    cur_tag = "R4";
    push(3'd5, RW'(4), 3'b011, srcs(1, 2, 0));
    push(3'd1, RW'(5), 3'b001, srcs(9, 0, 0));
    push(3'd0, RW'(6), 3'b000, '0);
    push(3'd5, RW'(7), 3'b011, srcs(3, 11, 0));
    do_flush();

    // R5: second branch closes
    cur_tag = "R5";
    push(3'd6, RW'(3), 3'b001, srcs(12, 0, 0));
    push(3'd2, RW'(13), 3'b000, '0);
    push(3'd6, RW'(3), 3'b010, srcs(0, 14, 0));
    do_flush();

    // R6: reads of a bundle result close it; branch destinations are not writes
    cur_tag = "R6";
    push(3'd6, RW'(9), 3'b000, '0);
    push(3'd0, RW'(15), 3'b100, srcs(0, 0, 9));
    push(3'd1, RW'(16), 3'b100, srcs(0, 0, 15));
    push(3'd6, RW'(0), 3'b001, srcs(16, 0, 0));
    do_flush();

    // R10: a no-op reading a bundle result is dropped without closing
    cur_tag = "R10";
    push(3'd0, RW'(17), 3'b000, '0);
    push(3'd7, RW'(18), 3'b001, srcs(17, 0, 0));
    push(3'd3, RW'(19), 3'b000, '0);
    do_flush();

    // R8: in_ready is low during flush; empty flush emits nothing
    cur_tag = "R8";
    push(3'd0, RW'(20), 3'b000, '0);
    m_emit();
    @(negedge clk);
    in_valid = 1; in_cls = 3'd0; in_dst = RW'(21); in_src_en = '0; in_src = '0;
    flush = 1;
    #1;
    check(in_ready == 0, "R8", "in_ready while flushing", BW'(in_ready), '0);
    @(posedge clk);
    #1 flush = 0; in_valid = 0;
    repeat (3) @(negedge clk);
    do_flush();
    repeat (4) begin
      @(negedge clk);
      #2;
      check(out_valid == 0, "R8", "no bundle from empty flush", BW'(out_valid), '0);
    end

    // R9: output stalled while a bundle must close
    cur_tag = "R9";
    bp_mode = 2;
    push(3'd4, RW'(1), 3'b000, '0);
    push(3'd4, RW'(2), 3'b000, '0);
    @(negedge clk);
    in_valid = 1; in_cls = 3'd4; in_dst = RW'(3); in_src_en = '0; in_src = '0;
    #1;
    check(in_ready == 0, "R9", "in_ready with full output", BW'(in_ready), '0);
    check(out_valid == 1, "R9", "held bundle present", BW'(out_valid), BW'(1));
    begin
      logic [BW-1:0] held;
      held = {out_alu_mask, out_br_valid, out_cls, out_dst, out_src_en, out_src,
              out_br_src_en, out_br_src};
      repeat (3) @(negedge clk);
      #1;
      check({out_alu_mask, out_br_valid, out_cls, out_dst, out_src_en, out_src,
             out_br_src_en, out_br_src} == held, "R9", "held bundle stable",
            {out_alu_mask, out_br_valid, out_cls, out_dst, out_src_en, out_src,
             out_br_src_en, out_br_src}, held);
      check(in_ready == 0, "R9", "in_ready still low", BW'(in_ready), '0);
    end
    bp_mode = 0;
    push(3'd4, RW'(3), 3'b000, '0);
    do_flush();

    // R7: long random stream with heavy dependence and random backpressure
    cur_tag = "R7";
    bp_mode = 1;
    for (int n = 0; n < 800; n++) begin
      rnd = step(rnd);
      push(rnd[2:0], RW'(rnd[4:3]), rnd[7:5],
           srcs(int'(rnd[9:8]), int'(rnd[11:10]), int'(rnd[13:12])));
      if (rnd[19:14] == 0) do_flush();
    end
    do_flush();
    bp_mode = 0;
    for (int w = 0; w < 50 && exp_q.size() != 0; w++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R7", "all bundles delivered", BW'(exp_q.size()), '0);
    finish_run();
  end
endmodule